// File: doc/BRIEF.md
# Tiled Aperture Fence Register Bank

This block keeps a small set of fence descriptors. Each descriptor marks one tiled window of a linear graphics aperture. A host loads the descriptors through a simple 32-bit register port. Every descriptor is 64 bits wide and is loaded as two separate 32-bit words. The low word carries a valid bit, and that bit gates matching. So a host that follows the safe order never exposes a half-built fence: it clears the low word, writes the high word, then writes the low word with valid set.

Aperture addresses arrive on a valid/ready lookup stream. The block compares the page number of each address against every valid fence. The lowest-numbered matching fence is chosen. One cycle later a registered result leaves on a valid/ready result stream. The result holds a hit flag, the fence number, the tiling orientation and the surface stride in bytes, which a downstream detiler uses to rearrange the address.

Back-pressure rules:
- The block holds one result.
- A lookup is taken on a clock edge where `lk_valid` and `lk_ready` are both high.
- `lk_ready` is high whenever the result slot is empty or the slot is being drained in the same cycle (`res_ready` high).
- While `res_valid` is high and `res_ready` is low, every result field stays unchanged.

Rounding a window down to whole tile rows is the writer's job. A tile row is stride × 8 lines for X tiling and stride × 32 lines for Y tiling. The block takes the stored last page as final.

Top module: `tile_fence_bank`

## Requirements
- R1: After reset every stored word reads as zero and `res_valid` is low.
- R2: Register byte offset 8n selects the low word of fence n, and offset 8n+4 selects its high word. Address bits 1:0 are ignored. A read returns the full 32-bit word as last written, and a write is readable on the following cycle.
- R3: Low-word fields are as follows. Bit 0 is valid. Bit 1 is Y tiling (1 = Y, 0 = X). Bits 11:2 hold the pitch. Bits 31:12 hold the first page. In the high word, bits 31:12 hold the last page, inclusive. The result reports the Y bit of the selected fence in `res_ytile`.
- R4: A lookup hits fence n when fence n is valid and the lookup page (address bits 31:12) is at least the first page and at most the last page.
- R5: A fence whose valid bit is clear never produces a hit. This includes the window between the two halves of the update sequence.
- R6: When several fences match, `res_index` reports the lowest-numbered one.
- R7: On a hit, `res_stride` equals (pitch + 1) × 128 bytes.
- R8: On a miss, `res_hit`, `res_index`, `res_ytile` and `res_stride` are all zero.
- R9: A lookup is accepted when `lk_valid` and `lk_ready` are both high. Its result appears with `res_valid` on the next cycle. `lk_ready` equals `!res_valid || res_ready`, and the result is held stable while stalled.
- R10: A lookup accepted in the same cycle as a register write sees the fence contents as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Word at `reg_addr` (combinational) |
| lk_valid | input | 1 | Lookup address valid |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_addr | input | 32 | Aperture byte address to classify |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Downstream takes the result |
| res_hit | output | 1 | Address falls in a valid fence |
| res_index | output | 4 | Number of the selected fence |
| res_ytile | output | 1 | Selected fence uses Y tiling |
| res_stride | output | 18 | Stride of the selected fence in bytes |

## Verification
Some behaviours are checked by assertions on every cycle:
- every register write is readable on the next cycle;
- no hit is ever reported against a fence that was invalid when the lookup was taken;
- the reported fence is the lowest-numbered one in the hit vector;
- miss results carry all-zero fields;
- a stalled result does not move.

Other behaviours only the bench scenarios can show, because they depend on the values programmed:
- inclusive page boundaries at both ends of a window;
- the byte stride decoded from the pitch field;
- the three-write update sequence seen from a lookup stream running alongside it;
- write-versus-lookup ordering in a shared cycle.

// File: rtl/tile_fence_pkg.sv
package tile_fence_pkg;
  localparam int WORD_W           = 32;
  localparam int PAGE_LSB         = 12;
  localparam int PAGE_W           = WORD_W - PAGE_LSB;
  localparam int PITCH_W          = 10;
  localparam int STRIDE_UNIT_LOG2 = 7;
  localparam int STRIDE_W         = PITCH_W + 1 + STRIDE_UNIT_LOG2;

  // low word: first page, pitch, Y select, valid (bit 0)
  typedef struct packed {
    logic [PAGE_W-1:0]  first_pg;
    logic [PITCH_W-1:0] pitch;
    logic               ytile;
    logic               valid;
  } fence_lo_t;

  // high word: last page, low bits kept only for read-back
  typedef struct packed {
    logic [PAGE_W-1:0]   last_pg;
    logic [PAGE_LSB-1:0] spare;
  } fence_hi_t;
endpackage

// File: rtl/tile_fence_regs.sv
module tile_fence_regs
  import tile_fence_pkg::*;
#(
  parameter int NUM_FENCES = 16,
  parameter int IDX_W      = $clog2(NUM_FENCES),
  parameter int REG_AW     = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] lo_q [NUM_FENCES],
  output logic [WORD_W-1:0] hi_q [NUM_FENCES]
);
  logic [IDX_W-1:0] sel_idx;
  logic             sel_hi;
  logic             unused_addr_lsb;

  assign sel_idx         = addr[REG_AW-1:3];
  assign sel_hi          = addr[2];
  assign unused_addr_lsb = ^addr[1:0];

  for (genvar g = 0; g < NUM_FENCES; g++) begin : g_fence
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else if (wr_en && sel_idx == IDX_W'(g)) begin
        if (sel_hi) hi_q[g] <= wdata;
        else        lo_q[g] <= wdata;
      end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_idx == IDX_W'(g)) |=>
        (($past(sel_hi) ? hi_q[g] : lo_q[g]) == $past(wdata))); // R2
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_FENCES; i++) begin
      if (sel_idx == IDX_W'(i)) rdata = sel_hi ? hi_q[i] : lo_q[i];
    end
  end
endmodule

// File: rtl/tile_fence_match.sv
module tile_fence_match
  import tile_fence_pkg::*;
#(
  parameter int NUM_FENCES = 16,
  parameter int IDX_W      = $clog2(NUM_FENCES)
) (
  input  logic [WORD_W-1:0]     lo_q [NUM_FENCES],
  input  logic [WORD_W-1:0]     hi_q [NUM_FENCES],
  input  logic [WORD_W-1:0]     addr,
  output logic [NUM_FENCES-1:0] hit_vec,
  output logic                  hit,
  output logic [IDX_W-1:0]      idx,
  output logic                  ytile,
  output logic [STRIDE_W-1:0]   stride
);
  logic [PAGE_W-1:0]   page;
  fence_lo_t           lo_f  [NUM_FENCES];
  fence_hi_t           hi_f  [NUM_FENCES];
  logic [STRIDE_W-1:0] str_f [NUM_FENCES];
  logic [NUM_FENCES-1:0] unused_hi_spare;
  logic                unused_addr_off;

  assign page            = addr[WORD_W-1:PAGE_LSB];
  assign unused_addr_off = ^addr[PAGE_LSB-1:0];

  for (genvar g = 0; g < NUM_FENCES; g++) begin : g_cmp
    assign lo_f[g]  = fence_lo_t'(lo_q[g]);
    assign hi_f[g]  = fence_hi_t'(hi_q[g]);
    assign str_f[g] = (STRIDE_W'({1'b0, lo_f[g].pitch}) + STRIDE_W'(1)) << STRIDE_UNIT_LOG2;
    assign hit_vec[g] = lo_f[g].valid && (page >= lo_f[g].first_pg)
                        && (page <= hi_f[g].last_pg);
    assign unused_hi_spare[g] = ^hi_f[g].spare;
  end

  // scan downward so the lowest matching index is the one left standing
  always_comb begin
    hit    = 1'b0;
    idx    = '0;
    ytile  = 1'b0;
    stride = '0;
    for (int i = NUM_FENCES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit    = 1'b1;
        idx    = IDX_W'(i);
        ytile  = lo_f[i].ytile;
        stride = str_f[i];
      end
    end
  end
endmodule

// File: rtl/tile_fence_result.sv
module tile_fence_result
  import tile_fence_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_hit,
  input  logic [IDX_W-1:0]    in_idx,
  input  logic                in_ytile,
  input  logic [STRIDE_W-1:0] in_stride,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_hit,
  output logic [IDX_W-1:0]    out_idx,
  output logic                out_ytile,
  output logic [STRIDE_W-1:0] out_stride
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_idx    <= '0;
      out_ytile  <= 1'b0;
      out_stride <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit    <= in_hit;
        out_idx    <= in_idx;
        out_ytile  <= in_ytile;
        out_stride <= in_stride;
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_idx)
      && $stable(out_ytile) && $stable(out_stride))); // R9

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_idx == '0 && !out_ytile && out_stride == '0)); // R8
endmodule

// File: rtl/tile_fence_bank.sv
module tile_fence_bank
  import tile_fence_pkg::*;
#(
  parameter int NUM_FENCES = 16,
  localparam int IDX_W     = $clog2(NUM_FENCES),
  localparam int REG_AW    = IDX_W + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic                lk_valid,
  output logic                lk_ready,
  input  logic [WORD_W-1:0]   lk_addr,
  output logic                res_valid,
  input  logic                res_ready,
  output logic                res_hit,
  output logic [IDX_W-1:0]    res_index,
  output logic                res_ytile,
  output logic [STRIDE_W-1:0] res_stride
);
  logic [WORD_W-1:0]     lo_q [NUM_FENCES];
  logic [WORD_W-1:0]     hi_q [NUM_FENCES];
  logic [NUM_FENCES-1:0] hit_vec;
  logic [NUM_FENCES-1:0] vld_vec;
  logic                  m_hit;
  logic [IDX_W-1:0]      m_idx;
  logic                  m_ytile;
  logic [STRIDE_W-1:0]   m_stride;

  tile_fence_regs #(.NUM_FENCES(NUM_FENCES), .IDX_W(IDX_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .lo_q(lo_q), .hi_q(hi_q)
  );

  tile_fence_match #(.NUM_FENCES(NUM_FENCES), .IDX_W(IDX_W)) u_match (
    .lo_q(lo_q), .hi_q(hi_q), .addr(lk_addr), .hit_vec(hit_vec),
    .hit(m_hit), .idx(m_idx), .ytile(m_ytile), .stride(m_stride)
  );

  tile_fence_result #(.IDX_W(IDX_W)) u_result (
    .clk(clk), .rst_n(rst_n), .in_valid(lk_valid), .in_ready(lk_ready),
    .in_hit(m_hit), .in_idx(m_idx), .in_ytile(m_ytile), .in_stride(m_stride),
    .out_valid(res_valid), .out_ready(res_ready), .out_hit(res_hit),
    .out_idx(res_index), .out_ytile(res_ytile), .out_stride(res_stride)
  );

  for (genvar g = 0; g < NUM_FENCES; g++) begin : g_vld
    assign vld_vec[g] = lo_q[g][0];
  end

  AST_INVALID_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=>
      (!res_hit || ((($past(vld_vec) >> res_index) & NUM_FENCES'(1)) != '0))); // R5

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    m_hit |-> (hit_vec[m_idx] &&
      ((hit_vec & ((NUM_FENCES'(1) << m_idx) - NUM_FENCES'(1))) == '0))); // R6
endmodule

// File: tb/tile_fence_bank_tb.sv
module tile_fence_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit;
  logic [3:0]  res_index;
  logic        res_ytile;
  logic [17:0] res_stride;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  string cur_tag = "R4";

  bit [31:0] m_lo [16];
  bit [31:0] m_hi [16];
  bit        e_valid = 0;
  bit        e_hit = 0;
  int        e_idx = 0;
  bit        e_y = 0;
  int        e_stride = 0;

  always #2.5 clk = ~clk;

  tile_fence_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_ready(res_ready), .res_hit(res_hit), .res_index(res_index),
    .res_ytile(res_ytile), .res_stride(res_stride)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // reference model, updated on each rising edge from the inputs held since #1 after the last edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
      e_valid = 0; e_hit = 0; e_idx = 0; e_y = 0; e_stride = 0;
    end else begin
      if (!e_valid || res_ready) begin
        e_valid = lk_valid;
        if (lk_valid) begin
          e_hit = 0; e_idx = 0; e_y = 0; e_stride = 0;
          for (int i = 0; i < 16; i++) begin
            if (!e_hit && m_lo[i][0] && lk_addr[31:12] >= m_lo[i][31:12]
                && lk_addr[31:12] <= m_hi[i][31:12]) begin
              e_hit = 1; e_idx = i; e_y = m_lo[i][1];
              e_stride = (int'(m_lo[i][11:2]) + 1) * 128;
            end
          end
        end
      end
      if (reg_wr_en) begin
        if (reg_addr[2]) m_hi[reg_addr[6:3]] = reg_wdata;
        else             m_lo[reg_addr[6:3]] = reg_wdata;
      end
    end
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      finish_run();
    end
  end

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9", "lk_ready", lk_ready, !e_valid || res_ready);
      chk("R9", "res_valid", res_valid, e_valid);
      if (e_valid) begin
        chk(cur_tag, "res_hit", res_hit, e_hit);
        chk(e_hit ? "R6" : "R8", "res_index", res_index, e_idx);
        chk("R3", "res_ytile", res_ytile, e_y);
        chk(e_hit ? "R7" : "R8", "res_stride", res_stride, e_stride);
      end
    end
  end

  task automatic step(input bit wr, input bit [6:0] wa, input bit [31:0] wd,
                      input bit lv, input bit [31:0] la, input bit rr);
    @(posedge clk); #1;
    reg_wr_en = wr; reg_addr = wa; reg_wdata = wd;
    lk_valid = lv; lk_addr = la; res_ready = rr;
  endtask

  task automatic rd(input string tag, input bit [6:0] a, input bit [31:0] exp);
    @(posedge clk); #1;
    reg_wr_en = 0; reg_addr = a; lk_valid = 0; res_ready = 1;
    #1 chk(tag, "reg_rdata", reg_rdata, exp);
  endtask

  // safe three-write update with a lookup running alongside each write
  task automatic prog(input int n, input bit [31:0] lo, input bit [31:0] hi, input bit [31:0] la);
    step(1, 7'(n * 8), 32'h0, 1, la, 1);
    step(1, 7'(n * 8 + 4), hi, 1, la, 1);
    step(1, 7'(n * 8), lo, 1, la, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1", "res_valid in reset", res_valid, 0);
    rst_n = 1;
    for (int i = 0; i < 32; i++) rd("R1", 7'(i * 4), 32'h0);

    // fence 0: pages 0x100..0x1FF, X, pitch 3 -> 512 B
    prog(0, 32'h0010_000D, 32'h001F_F000, 32'h0010_0000);
    // fence 2: pages 0x180..0x300, Y, pitch 7 -> 1024 B; spare bits kept
    prog(2, 32'h0018_001F, 32'h0030_0ABC, 32'h0020_0000);
    // fence 5: single page 0x80000, pitch 0
    prog(5, 32'h8000_0001, 32'h8000_0000, 32'h8000_0123);

    rd("R2", 7'd23, 32'h0030_0ABC);
    rd("R2", 7'd16, 32'h0018_001F);
    rd("R2", 7'd41, 32'h8000_0001);

    cur_tag = "R4";
    step(0, 0, 0, 1, 32'h0010_0000, 1);
    step(0, 0, 0, 1, 32'h001F_FFFF, 1);
    step(0, 0, 0, 1, 32'h000F_FFFF, 1);
    step(0, 0, 0, 1, 32'h0020_0000, 1);
    step(0, 0, 0, 1, 32'h0030_0FFF, 1);
    step(0, 0, 0, 1, 32'h0030_1000, 1);
    step(0, 0, 0, 1, 32'h8000_0FFF, 1);
    step(0, 0, 0, 1, 32'h8000_1000, 1);
    cur_tag = "R6";
    step(0, 0, 0, 1, 32'h0018_0000, 1);
    step(0, 0, 0, 1, 32'h001F_F800, 1);

    // R5: move fence 5 while lookups target its new window
    cur_tag = "R5";
    prog(5, 32'h9000_0005, 32'h9000_1000, 32'h9000_0010);
    step(0, 0, 0, 1, 32'h9000_0010, 1);
    step(0, 0, 0, 1, 32'h9000_1010, 1);
    step(1, 7'd40, 32'h9000_0004, 1, 32'h9000_0010, 1);
    step(0, 0, 0, 1, 32'h9000_0010, 1);

    // R9: stall the result stream
    cur_tag = "R4";
    step(0, 0, 0, 1, 32'h0010_0000, 0);
    step(0, 0, 0, 1, 32'h0020_0000, 0);
    step(0, 0, 0, 1, 32'h0030_0000, 0);
    step(0, 0, 0, 1, 32'h0030_0000, 1);
    step(0, 0, 0, 0, 32'h0, 0);
    step(0, 0, 0, 0, 32'h0, 1);

    // R10: write and lookup in the same cycle
    cur_tag = "R10";
    step(1, 7'd0, 32'h0, 1, 32'h0010_0000, 1);
    step(0, 0, 0, 1, 32'h0010_0000, 1);
    step(1, 7'd0, 32'h0010_000D, 1, 32'h0010_0000, 1);
    step(0, 0, 0, 1, 32'h0010_0000, 1);

    // mixed traffic
    cur_tag = "R4";
    for (int k = 0; k < 400; k++) begin
      bit [31:0] pick;
      case ($urandom_range(0, 5))
        0: pick = 32'h0010_0000;
        1: pick = 32'h0018_0400;
        2: pick = 32'h8000_0000;
        3: pick = 32'h9000_0000;
        4: pick = {$urandom_range(0, 3) == 0 ? 12'h001 : 12'h900, 20'h0};
        default: pick = $urandom;
      endcase
      step($urandom_range(0, 7) == 0, 7'($urandom_range(0, 127)),
           {$urandom_range(0, 1) ? 12'h001 : 12'h900, 8'($urandom), 12'($urandom)},
           $urandom_range(0, 3) != 0, pick, $urandom_range(0, 3) != 0);
    end
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 32; i++)
      rd("R2", 7'(i * 4), (i % 2) ? m_hi[i / 2] : m_lo[i / 2]);
    finish_run();
  end
endmodule